// File: doc/BRIEF.md
# Scratchpad-Buffered Protected Page Memory

This block holds a 512-byte main array organised as 16 pages of 32 bytes. The host never writes the array directly. Each write goes through three steps. The host first loads a 32-byte scratchpad, starting at a target address. It then reads the buffered data back to confirm it. Finally it authorizes a copy by echoing the target address and the status byte that the block reports.

A copy then programs the bytes from the starting offset to the last offset written into the target page. It does this one byte per clock, under a self-timed busy window that stands in for the slow programming cycle of a non-volatile array.

Each page carries a protection mode, loaded through a separate register port:
- **open**: the page takes the new data.
- **locked**: the page ignores every copy.
- **one-time-programmable emulation**: a copy can only clear bits, so the stored byte becomes the old byte AND the new byte.

Top module: `spadPageMem`

## Requirements
- R1: After reset the outputs are as follows: `busy`, `rdValid`, `copyAck` and `copyNak` are low, and `targetAddr` and `esByte` are zero. Every page is open, and every main-array byte reads 8'hFF.
- R2: Opcode 1 (start) loads `targetAddr` from `opAddr` and sets the write offset to `opAddr[4:0]`. Opcode 2 (byte) stores `opData` at the current offset and advances it. Opcode 3 returns scratchpad byte `opAddr[4:0]`, and opcode 5 returns main-array byte `opAddr`. Both reads present the byte on `rdData` with `rdValid` high in the cycle after the request.
- R3: Once offset 31 has been written, further byte requests are ignored. Writing never wraps to the start of the scratchpad.
- R4: `esByte` is laid out as follows:
  - bit 7 is the copied flag, cleared by a start request;
  - bits 6:5 are zero;
  - bits 4:0 hold the offset of the last byte written, or the starting offset if no byte has been written yet.
- R5: A copy request (opcode 4) is rejected, with `copyNak` high in the next cycle, when any of these holds:
  - `opAddr` differs from `targetAddr`;
  - `opStatus` differs from `esByte`;
  - the copied flag is already set.

  A rejected copy leaves the main array unchanged.
- R6: An accepted copy raises `copyAck` in the next cycle and sets `esByte[7]`. In that same cycle `busy` rises and then stays high for exactly PROG_CYCLES cycles.
- R7: In an open page (mode 0), a copy replaces the bytes from the starting offset to the ending offset with the scratchpad bytes. All other bytes in the page keep their old values.
- R8: In a locked page (mode 1 or 3), an accepted copy leaves every byte of the page unchanged.
- R9: In an emulation page (mode 2), a copy stores the old byte ANDed with the scratchpad byte.
- R10: While `busy` is high, every copy request is rejected, and start and byte requests have no effect.
- R11: When `protWe` is high, page `protPage` takes mode `protMode`, and the new mode governs every later copy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| opValid | input | 1 | Request valid this cycle |
| opCode | input | 3 | 1 start, 2 byte, 3 scratch read, 4 copy, 5 array read |
| opAddr | input | 9 | Target address, read address or copy address echo |
| opData | input | 8 | Byte to buffer |
| opStatus | input | 8 | Status byte echoed with a copy |
| protWe | input | 1 | Protection mode write strobe |
| protPage | input | 4 | Page whose mode is written |
| protMode | input | 2 | 0 open, 1 or 3 locked, 2 emulation |
| rdData | output | 8 | Read result |
| rdValid | output | 1 | Read result valid |
| busy | output | 1 | Programming window active |
| copyAck | output | 1 | Copy accepted |
| copyNak | output | 1 | Copy rejected |
| targetAddr | output | 9 | Buffered target address |
| esByte | output | 8 | Copied flag and ending offset |

## Verification
The hardest situation to reach is a request that lands inside the programming window. Those requests must be refused, and they must not disturb the buffer that is still being programmed. The bench issues a second copy, a stray byte and a fresh start in the cycles right after an accepted copy, while `busy` is still high. Afterwards it reads the scratchpad, the status byte and the target address back to show that nothing moved. Emulation mode is driven twice into the same bytes, so the second result shows a true AND with stored data rather than a plain overwrite.

// File: rtl/spadPkg.sv
package spadPkg;
  parameter int PAGES      = 16;
  parameter int PAGE_BYTES = 32;
  parameter int OFF_W      = $clog2(PAGE_BYTES);
  parameter int PG_W       = $clog2(PAGES);
  parameter int ADDR_W     = OFF_W + PG_W;
  parameter int MEM_BYTES  = PAGES * PAGE_BYTES;

  typedef enum logic [2:0] {
    OP_IDLE     = 3'd0,
    OP_SP_START = 3'd1,
    OP_SP_BYTE  = 3'd2,
    OP_SP_READ  = 3'd3,
    OP_COPY     = 3'd4,
    OP_MEM_READ = 3'd5
  } opT;

  localparam logic [1:0] MODE_OPEN = 2'd0;
  localparam logic [1:0] MODE_OTP  = 2'd2;

  typedef struct packed {
    logic              spWe;
    logic              spRd;
    logic [OFF_W-1:0]  spIdx;
    logic [7:0]        spData;
    logic              memRd;
    logic [ADDR_W-1:0] rdAddr;
    logic              memWe;
    logic [ADDR_W-1:0] wrAddr;
  } strobeT;
endpackage

// File: rtl/spadCtrl.sv
module spadCtrl
  import spadPkg::*;
#(
  parameter int PROG_CYCLES = 40
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              opValid,
  input  logic [2:0]        opCode,
  input  logic [ADDR_W-1:0] opAddr,
  input  logic [7:0]        opData,
  input  logic [7:0]        opStatus,
  output strobeT            strb,
  output logic              busy,
  output logic              copyAck,
  output logic              copyNak,
  output logic [ADDR_W-1:0] targetAddr,
  output logic [7:0]        esByte
);
  localparam int CNT_W = $clog2(PROG_CYCLES + 1);
  localparam int PAD_W = 7 - OFF_W;
  localparam logic [OFF_W-1:0] LAST_OFF = OFF_W'(PAGE_BYTES - 1);

  opT opK;
  logic [OFF_W-1:0] curOff, endOff, progIdx;
  logic full, copied, progOn, accept, isCopy;
  logic [CNT_W-1:0] cnt;

  assign opK    = opT'(opCode);
  assign busy   = (cnt != '0);
  assign esByte = {copied, {PAD_W{1'b0}}, endOff};
  assign isCopy = opValid && (opK == OP_COPY);
  assign accept = isCopy && !busy && !copied && (opAddr == targetAddr) && (opStatus == esByte);

  always_comb begin
    strb.spWe   = opValid && (opK == OP_SP_BYTE) && !busy && !full;
    strb.spRd   = opValid && (opK == OP_SP_READ);
    strb.spIdx  = (opK == OP_SP_READ) ? opAddr[OFF_W-1:0] : curOff;
    strb.spData = opData;
    strb.memRd  = opValid && (opK == OP_MEM_READ);
    strb.rdAddr = opAddr;
    strb.memWe  = progOn;
    strb.wrAddr = {targetAddr[ADDR_W-1:OFF_W], progIdx};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      targetAddr <= '0;
      curOff     <= '0;
      endOff     <= '0;
      full       <= 1'b0;
      copied     <= 1'b0;
      cnt        <= '0;
      progIdx    <= '0;
      progOn     <= 1'b0;
      copyAck    <= 1'b0;
      copyNak    <= 1'b0;
    end else begin
      copyAck <= accept;
      copyNak <= isCopy && !accept;
      if (opValid && (opK == OP_SP_START) && !busy) begin
        targetAddr <= opAddr;
        curOff     <= opAddr[OFF_W-1:0];
        endOff     <= opAddr[OFF_W-1:0];
        full       <= 1'b0;
        copied     <= 1'b0;
      end
      if (strb.spWe) begin
        endOff <= curOff;
        if (curOff == LAST_OFF) full <= 1'b1;
        else curOff <= curOff + 1'b1;
      end
      if (progOn) begin
        if (progIdx == endOff) progOn <= 1'b0;
        else progIdx <= progIdx + 1'b1;
      end
      if (accept) begin
        cnt     <= CNT_W'(PROG_CYCLES);
        copied  <= 1'b1;
        progIdx <= targetAddr[OFF_W-1:0];
        progOn  <= 1'b1;
      end else if (busy) begin
        cnt <= cnt - 1'b1;
      end
    end
  end

  // R5 / R6: a copy request gets one answer, never both
  assert_ack_nak_excl_R5: assert property (@(posedge clk) disable iff (!rstN)
    !(copyAck && copyNak));

  // R6: an accepted copy opens the busy window in the same cycle
  assert_busy_on_ack_R6: assert property (@(posedge clk) disable iff (!rstN)
    copyAck |-> busy);

  // R10: a copy request that arrives while busy is refused
  assert_no_copy_busy_R10: assert property (@(posedge clk) disable iff (!rstN)
    (busy && isCopy) |=> (copyNak && !copyAck));

  // R6: array programming only happens inside the busy window
  assert_prog_in_busy_R6: assert property (@(posedge clk) disable iff (!rstN)
    strb.memWe |-> busy);

  // R3: the write offset never leaves the page
  assert_end_stays_R3: assert property (@(posedge clk) disable iff (!rstN)
    (full && !(opValid && opK == OP_SP_START)) |=> (endOff == LAST_OFF));
endmodule

// File: rtl/spadDatapath.sv
module spadDatapath
  import spadPkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  strobeT          strb,
  input  logic            protWe,
  input  logic [PG_W-1:0] protPage,
  input  logic [1:0]      protMode,
  output logic [7:0]      rdData,
  output logic            rdValid
);
  logic [7:0] spMem   [PAGE_BYTES];
  logic [7:0] mainMem [MEM_BYTES];
  logic [1:0] pageMode [PAGES];

  logic [PG_W-1:0]  wrPage;
  logic [OFF_W-1:0] wrOff;
  logic [1:0]       wrMode;
  logic [7:0]       newByte;
  logic             doWrite;

  assign wrPage  = strb.wrAddr[ADDR_W-1:OFF_W];
  assign wrOff   = strb.wrAddr[OFF_W-1:0];
  assign wrMode  = pageMode[wrPage];
  assign doWrite = strb.memWe && ((wrMode == MODE_OPEN) || (wrMode == MODE_OTP));

  always_comb begin
    if (wrMode == MODE_OTP) newByte = mainMem[strb.wrAddr] & spMem[wrOff];
    else newByte = spMem[wrOff];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < PAGE_BYTES; i++) spMem[i] <= '0;
      for (int p = 0; p < PAGES; p++) pageMode[p] <= MODE_OPEN;
    end else begin
      if (strb.spWe) spMem[strb.spIdx] <= strb.spData;
      if (protWe) pageMode[protPage] <= protMode;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < MEM_BYTES; i++) mainMem[i] <= 8'hFF;
    end else if (doWrite) begin
      mainMem[strb.wrAddr] <= newByte;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdValid <= 1'b0;
      rdData  <= '0;
    end else begin
      rdValid <= strb.spRd || strb.memRd;
      if (strb.spRd) rdData <= spMem[strb.spIdx];
      else if (strb.memRd) rdData <= mainMem[strb.rdAddr];
    end
  end

  // R8: a programming step into a locked page changes nothing
  assert_lock_stable_R8: assert property (@(posedge clk) disable iff (!rstN)
    (strb.memWe && !protWe && (wrMode != MODE_OPEN) && (wrMode != MODE_OTP))
      |=> (mainMem[$past(strb.wrAddr)] == $past(mainMem[strb.wrAddr])));

  // R9: emulation mode never sets a bit that was clear
  assert_otp_no_set_R9: assert property (@(posedge clk) disable iff (!rstN)
    (strb.memWe && !protWe && (wrMode == MODE_OTP))
      |=> ((mainMem[$past(strb.wrAddr)] & ~$past(mainMem[strb.wrAddr])) == 8'h00));
endmodule

// File: rtl/spadPageMem.sv
module spadPageMem
  import spadPkg::*;
#(
  parameter int PROG_CYCLES = 40
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              opValid,
  input  logic [2:0]        opCode,
  input  logic [ADDR_W-1:0] opAddr,
  input  logic [7:0]        opData,
  input  logic [7:0]        opStatus,
  input  logic              protWe,
  input  logic [PG_W-1:0]   protPage,
  input  logic [1:0]        protMode,
  output logic [7:0]        rdData,
  output logic              rdValid,
  output logic              busy,
  output logic              copyAck,
  output logic              copyNak,
  output logic [ADDR_W-1:0] targetAddr,
  output logic [7:0]        esByte
);
  strobeT strb;

  spadCtrl #(.PROG_CYCLES(PROG_CYCLES)) uCtrl (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opCode(opCode),
    .opAddr(opAddr), .opData(opData), .opStatus(opStatus), .strb(strb),
    .busy(busy), .copyAck(copyAck), .copyNak(copyNak),
    .targetAddr(targetAddr), .esByte(esByte)
  );

  spadDatapath uData (
    .clk(clk), .rstN(rstN), .strb(strb), .protWe(protWe),
    .protPage(protPage), .protMode(protMode),
    .rdData(rdData), .rdValid(rdValid)
  );

  // R6: the window must cover programming a whole page
  initial assert_prog_len_R6: assert (PROG_CYCLES >= PAGE_BYTES);
endmodule

// File: tb/sim_spadPageMem.sv
`timescale 1ns/1ps
module sim_spadPageMem;
  localparam int PROG = 40;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic opValid = 1'b0;
  logic [2:0] opCode = '0;
  logic [8:0] opAddr = '0;
  logic [7:0] opData = '0, opStatus = '0;
  logic protWe = 1'b0;
  logic [3:0] protPage = '0;
  logic [1:0] protMode = '0;
  logic [7:0] rdData, esByte;
  logic rdValid, busy, copyAck, copyNak;
  logic [8:0] targetAddr;

  int nChecks = 0, nErrors = 0, busyCnt = 0;
  logic [7:0] expQ[$];
  string tagQ[$];

  always #2 clk = ~clk;

  spadPageMem #(.PROG_CYCLES(PROG)) u0 (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opCode(opCode), .opAddr(opAddr),
    .opData(opData), .opStatus(opStatus), .protWe(protWe), .protPage(protPage),
    .protMode(protMode), .rdData(rdData), .rdValid(rdValid), .busy(busy),
    .copyAck(copyAck), .copyNak(copyNak), .targetAddr(targetAddr), .esByte(esByte)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErrors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops the scoreboard whenever a read result appears
  always @(negedge clk) begin
    if (busy) busyCnt++;
    if (rstN && rdValid) begin
      if (expQ.size() == 0) begin
        nChecks++; nErrors++;
        $display("FAIL R2 unexpected read actual=%h expected=none", rdData);
      end else begin
        check(tagQ.pop_front(), {8'h0, rdData}, {8'h0, expQ.pop_front()});
      end
    end
  end

  task automatic doOp(input logic [2:0] c, input logic [8:0] a, input logic [7:0] d, input logic [7:0] s);
    opValid = 1'b1; opCode = c; opAddr = a; opData = d; opStatus = s;
    @(negedge clk);
    opValid = 1'b0; opCode = '0;
  endtask

  task automatic expectRd(input string tag, input logic [2:0] c, input logic [8:0] a, input logic [7:0] exp);
    expQ.push_back(exp); tagQ.push_back(tag);
    doOp(c, a, 8'h0, 8'h0);
  endtask

  task automatic setProt(input logic [3:0] p, input logic [1:0] m);
    protWe = 1'b1; protPage = p; protMode = m;
    @(negedge clk);
    protWe = 1'b0;
  endtask

  task automatic waitIdle();
    while (busy) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++; nErrors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    check("R1 busy", {15'h0, busy}, 16'h0);
    check("R1 rdValid", {15'h0, rdValid}, 16'h0);
    check("R1 acks", {14'h0, copyAck, copyNak}, 16'h0);
    check("R1 esByte", {8'h0, esByte}, 16'h0);
    check("R1 target", {7'h0, targetAddr}, 16'h0);
    expectRd("R1 erased", 3'd5, 9'h000, 8'hFF);
    expectRd("R1 erased hi", 3'd5, 9'h1FF, 8'hFF);

    // R11: page 1 emulation, page 2 locked
    setProt(4'd1, 2'd2);
    setProt(4'd2, 2'd1);

    // R2 / R4: four bytes into page 0 from offset 0
    doOp(3'd1, 9'h000, 8'h0, 8'h0);
    for (int i = 0; i < 4; i++) doOp(3'd2, 9'h0, 8'hA0 + 8'(i), 8'h0);
    check("R4 end offset", {8'h0, esByte}, 16'h0003);
    check("R2 target", {7'h0, targetAddr}, 16'h0000);
    expectRd("R2 sp readback", 3'd3, 9'h002, 8'hA2);

    // R5: bad status, bad address
    doOp(3'd4, 9'h000, 8'h0, 8'h02);
    check("R5 bad status nak", {14'h0, copyAck, copyNak}, 16'h1);
    doOp(3'd4, 9'h020, 8'h0, 8'h03);
    check("R5 bad addr nak", {14'h0, copyAck, copyNak}, 16'h1);
    expectRd("R5 array intact", 3'd5, 9'h000, 8'hFF);

    // R6: good copy
    busyCnt = 0;
    doOp(3'd4, 9'h000, 8'h0, 8'h03);
    check("R6 ack", {14'h0, copyAck, copyNak}, 16'h2);
    check("R6 busy rises", {15'h0, busy}, 16'h1);
    check("R6 copied flag", {8'h0, esByte}, 16'h0083);
    // R10: requests during busy
    doOp(3'd4, 9'h000, 8'h0, 8'h83);
    check("R10 copy while busy nak", {14'h0, copyAck, copyNak}, 16'h1);
    doOp(3'd2, 9'h0, 8'h55, 8'h0);
    doOp(3'd1, 9'h060, 8'h0, 8'h0);
    check("R10 start ignored", {7'h0, targetAddr}, 16'h0000);
    waitIdle();
    check("R6 busy length", 16'(busyCnt), 16'(PROG));
    check("R10 es unchanged", {8'h0, esByte}, 16'h0083);
    expectRd("R10 byte ignored", 3'd3, 9'h004, 8'h00);
    for (int i = 0; i < 4; i++) expectRd("R7 written", 3'd5, 9'(i), 8'hA0 + 8'(i));
    expectRd("R7 outside kept", 3'd5, 9'h004, 8'hFF);
    doOp(3'd4, 9'h000, 8'h0, 8'h83);
    check("R5 second copy nak", {14'h0, copyAck, copyNak}, 16'h1);

    // R3: start near page end, no wrap
    doOp(3'd1, 9'h03E, 8'h0, 8'h0);
    check("R4 start offset", {8'h0, esByte}, 16'h001E);
    doOp(3'd2, 9'h0, 8'h0F, 8'h0);
    doOp(3'd2, 9'h0, 8'hF0, 8'h0);
    doOp(3'd2, 9'h0, 8'h33, 8'h0);
    doOp(3'd2, 9'h0, 8'h44, 8'h0);
    check("R3 end saturates", {8'h0, esByte}, 16'h001F);
    expectRd("R3 last byte", 3'd3, 9'h01F, 8'hF0);
    expectRd("R3 no wrap", 3'd3, 9'h000, 8'hA0);

    // R9: emulation page, two rounds
    doOp(3'd4, 9'h03E, 8'h0, 8'h1F);
    check("R9 ack", {14'h0, copyAck, copyNak}, 16'h2);
    waitIdle();
    expectRd("R9 first", 3'd5, 9'h03E, 8'h0F);
    expectRd("R9 first hi", 3'd5, 9'h03F, 8'hF0);
    expectRd("R7 page1 before", 3'd5, 9'h03D, 8'hFF);
    doOp(3'd1, 9'h03E, 8'h0, 8'h0);
    doOp(3'd2, 9'h0, 8'h3C, 8'h0);
    doOp(3'd2, 9'h0, 8'hFF, 8'h0);
    doOp(3'd4, 9'h03E, 8'h0, 8'h1F);
    waitIdle();
    expectRd("R9 and", 3'd5, 9'h03E, 8'h0C);
    expectRd("R9 and hi", 3'd5, 9'h03F, 8'hF0);

    // R8: locked page
    doOp(3'd1, 9'h040, 8'h0, 8'h0);
    doOp(3'd2, 9'h0, 8'h11, 8'h0);
    doOp(3'd2, 9'h0, 8'h22, 8'h0);
    doOp(3'd4, 9'h040, 8'h0, 8'h01);
    check("R8 ack", {14'h0, copyAck, copyNak}, 16'h2);
    waitIdle();
    expectRd("R8 locked", 3'd5, 9'h040, 8'hFF);
    expectRd("R8 locked 2", 3'd5, 9'h041, 8'hFF);

    // R11: unlock page 2 and copy again
    setProt(4'd2, 2'd0);
    doOp(3'd1, 9'h040, 8'h0, 8'h0);
    doOp(3'd2, 9'h0, 8'h11, 8'h0);
    doOp(3'd4, 9'h040, 8'h0, 8'h00);
    waitIdle();
    expectRd("R11 reopened", 3'd5, 9'h040, 8'h11);
    expectRd("R11 neighbour", 3'd5, 9'h041, 8'hFF);

    repeat (2) @(negedge clk);
    check("R2 scoreboard drained", 16'(expQ.size()), 16'h0);
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end
endmodule